// File: doc/BRIEF.md
# Priority Suspend/Resume Sequencer

This block keeps a small table of tasks. Each task has a priority value and a flag that says whether it is running or suspended. On each tick pulse the block picks one task and says whether it is to be suspended or resumed. The block runs in two phases. In the first phase it drains the running set, starting with the most urgent task. In the second phase it refills the running set, starting with the least urgent suspended task. It then starts the drain again. The block updates its own table to match the event it issues, so the event stream is a test load that exercises a scheduler's priority handling.

A write port loads the priority of one entry and marks that entry as running. A configuration input sets how many entries take part, counted from index 0. A polarity input sets whether a numerically larger or a numerically smaller value counts as more urgent. The search visits one entry per clock, and a busy flag is high while it runs. A tick that arrives while the block is busy is not acted on; it is only counted.

Top module: `prio_seq_top`

## Requirements
- R1: After reset, busy and evValid are low, missCount is 0, every table entry is running, and the block is in the drain phase.
- R2: In the drain phase, a tick suspends the most urgent running task among entries 0 to taskCount-1. With bigIsHigh=1 a larger value is more urgent; with bigIsHigh=0 a smaller value is more urgent. Equal values resolve to the lower index.
- R3: When a suspend leaves exactly one task running, the block enters the refill phase.
- R4: In the refill phase, a tick resumes the least urgent suspended task among the active entries. Equal values resolve to the lower index.
- R5: When a resume leaves no task suspended, the block returns to the drain phase.
- R6: When taskCount is below 2, a tick starts no search, raises no busy and issues no event.
- R7: An accepted tick holds busy high for exactly taskCount+1 cycles. evValid is high for one cycle, in the cycle busy falls. In that cycle evIdx holds the task index and evAction holds the action: 0 for suspend, 1 for resume.
- R8: A tick seen while busy is high increments missCount, which saturates at its maximum. Such a tick does not change the pending event or the next event.
- R9: If the search ends in the refill phase with no suspended task, or in the drain phase with at most one running task, no event is issued and the phase flips.
- R10: A write with wrEn high while the block is idle sets the entry's priority and marks the entry running. A write while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Tick pulse requesting one action |
| bigIsHigh | input | 1 | 1: larger value is more urgent |
| taskCount | input | CNT_W | Number of participating entries |
| wrEn | input | 1 | Table write enable |
| wrIdx | input | IDX_W | Entry index to write |
| wrPri | input | PRI_W | Priority value to write |
| busy | output | 1 | Search in progress |
| evValid | output | 1 | One-cycle event strobe |
| evIdx | output | IDX_W | Task index of the event |
| evAction | output | 1 | 0 suspend, 1 resume |
| missCount | output | MISS_W | Saturating count of ticks seen while busy |

## Verification
The properties assume that taskCount and bigIsHigh stay stable while busy is high, and that taskCount never exceeds the table size. The index check in particular relies on this. The stimulus changes taskCount, the polarity and the table contents only while the block is idle. It keeps taskCount within 1 to 20. Extra ticks during a search are injected on purpose, so the miss counting and the rule that such ticks have no effect on events are covered.

// File: rtl/prio_seq_pkg.sv
package prio_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startScan;
    logic stepScan;
    logic seekResume;
    logic commit;
  } dp_ctrl_t;

  localparam logic ACT_SUSPEND = 1'b0;
  localparam logic ACT_RESUME  = 1'b1;

endpackage

// File: rtl/prio_seq_datapath.sv
module prio_seq_datapath
  import prio_seq_pkg::*;
#(
  parameter int MAX_TASKS = 20,
  parameter int PRI_W     = 8,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] taskCount,
  input  logic             bigIsHigh,
  input  logic             allowWrite,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [PRI_W-1:0] wrPri,
  output logic             scanLast,
  output logic             candFound,
  output logic [CNT_W-1:0] runTotal,
  output logic [CNT_W-1:0] suspTotal,
  output logic [IDX_W-1:0] evIdx
);

  logic [PRI_W-1:0] priTab [MAX_TASKS];
  logic             runTab [MAX_TASKS];

  logic [IDX_W-1:0] scanIdx;
  logic [IDX_W-1:0] candIdx;
  logic [PRI_W-1:0] candPri;
  logic [CNT_W-1:0] effCount;
  logic [IDX_W-1:0] lastIdx;
  logic [PRI_W-1:0] curPri;
  logic             curRun;
  logic             beats;
  logic             below;
  logic             take;

  // Clamp the active count to the table size
  always_comb begin
    if (taskCount > CNT_W'(MAX_TASKS)) effCount = CNT_W'(MAX_TASKS);
    else                               effCount = taskCount;
    lastIdx = IDX_W'(effCount - CNT_W'(1));
  end

  assign scanLast = (scanIdx == lastIdx);

  always_comb begin
    curPri = '0;
    curRun = 1'b0;
    for (int i = 0; i < MAX_TASKS; i++) begin
      if (scanIdx == IDX_W'(i)) begin
        curPri = priTab[i];
        curRun = runTab[i];
      end
    end
  end

  // Polarity-selectable strict comparisons; strictness keeps the lower index on ties
  always_comb begin
    beats = bigIsHigh ? (curPri > candPri) : (curPri < candPri);
    below = bigIsHigh ? (curPri < candPri) : (curPri > candPri);
    if (ctrl.seekResume) take = !curRun && (!candFound || below);
    else                 take =  curRun && (!candFound || beats);
  end

  // One register slice per table entry
  generate
    for (genvar g = 0; g < MAX_TASKS; g++) begin : g_entry
      logic wrHit;
      logic actHit;
      assign wrHit  = allowWrite && wrEn && (wrIdx == IDX_W'(g));
      assign actHit = ctrl.commit && (candIdx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          priTab[g] <= '0;
          runTab[g] <= 1'b1;
        end else if (wrHit) begin
          priTab[g] <= wrPri;
          runTab[g] <= 1'b1;
        end else if (actHit) begin
          runTab[g] <= ctrl.seekResume;
        end
      end
    end
  endgenerate

  // Sequential search state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx   <= '0;
      candIdx   <= '0;
      candPri   <= '0;
      candFound <= 1'b0;
      runTotal  <= '0;
      suspTotal <= '0;
    end else if (ctrl.startScan) begin
      scanIdx   <= '0;
      candIdx   <= '0;
      candPri   <= '0;
      candFound <= 1'b0;
      runTotal  <= '0;
      suspTotal <= '0;
    end else if (ctrl.stepScan) begin
      scanIdx <= scanIdx + IDX_W'(1);
      if (curRun) runTotal  <= runTotal + CNT_W'(1);
      else        suspTotal <= suspTotal + CNT_W'(1);
      if (take) begin
        candFound <= 1'b1;
        candIdx   <= scanIdx;
        candPri   <= curPri;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            evIdx <= '0;
    else if (ctrl.commit) evIdx <= candIdx;
  end

endmodule

// File: rtl/prio_seq_ctrl.sv
module prio_seq_ctrl
  import prio_seq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [CNT_W-1:0]  taskCount,
  input  logic              scanLast,
  input  logic              candFound,
  input  logic [CNT_W-1:0]  runTotal,
  input  logic [CNT_W-1:0]  suspTotal,
  output dp_ctrl_t          ctrl,
  output logic              busy,
  output logic              evValid,
  output logic              evAction,
  output logic [MISS_W-1:0] missCount
);

  phase_t phase;
  logic   modeResume;
  logic   countOk;
  logic   act;
  logic   flipMode;

  assign countOk = (taskCount >= CNT_W'(2));
  assign busy    = (phase != PH_IDLE);

  // Decide the outcome at the end of the search
  always_comb begin
    if (modeResume) begin
      act      = candFound && (suspTotal >= CNT_W'(1));
      flipMode = (suspTotal <= CNT_W'(1));
    end else begin
      act      = candFound && (runTotal >= CNT_W'(2));
      flipMode = (runTotal <= CNT_W'(2));
    end
  end

  always_comb begin
    ctrl.startScan  = (phase == PH_IDLE) && tickIn && countOk;
    ctrl.stepScan   = (phase == PH_SCAN);
    ctrl.seekResume = modeResume;
    ctrl.commit     = (phase == PH_DONE) && act;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      modeResume <= 1'b0;
      evValid    <= 1'b0;
      evAction   <= ACT_SUSPEND;
    end else begin
      evValid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (tickIn && countOk) phase <= PH_SCAN;
        PH_SCAN: if (scanLast) phase <= PH_DONE;
        PH_DONE: begin
          phase    <= PH_IDLE;
          evValid  <= act;
          evAction <= modeResume ? ACT_RESUME : ACT_SUSPEND;
          if (flipMode) modeResume <= !modeResume;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              missCount <= '0;
    else if (tickIn && busy && !(&missCount)) missCount <= missCount + MISS_W'(1);
  end

endmodule

// File: rtl/prio_seq_top.sv
module prio_seq_top
  import prio_seq_pkg::*;
#(
  parameter int MAX_TASKS = 20,
  parameter int PRI_W     = 8,
  parameter int MISS_W    = 8,
  localparam int IDX_W    = (MAX_TASKS > 1) ? $clog2(MAX_TASKS) : 1,
  localparam int CNT_W    = $clog2(MAX_TASKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              bigIsHigh,
  input  logic [CNT_W-1:0]  taskCount,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PRI_W-1:0]  wrPri,
  output logic              busy,
  output logic              evValid,
  output logic [IDX_W-1:0]  evIdx,
  output logic              evAction,
  output logic [MISS_W-1:0] missCount
);

  dp_ctrl_t         dpCtrl;
  logic             scanLast;
  logic             candFound;
  logic [CNT_W-1:0] runTotal;
  logic [CNT_W-1:0] suspTotal;

  prio_seq_ctrl #(.CNT_W(CNT_W), .MISS_W(MISS_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .taskCount (taskCount),
    .scanLast  (scanLast),
    .candFound (candFound),
    .runTotal  (runTotal),
    .suspTotal (suspTotal),
    .ctrl      (dpCtrl),
    .busy      (busy),
    .evValid   (evValid),
    .evAction  (evAction),
    .missCount (missCount)
  );

  prio_seq_datapath #(
    .MAX_TASKS(MAX_TASKS), .PRI_W(PRI_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (dpCtrl),
    .taskCount  (taskCount),
    .bigIsHigh  (bigIsHigh),
    .allowWrite (!busy),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrPri      (wrPri),
    .scanLast   (scanLast),
    .candFound  (candFound),
    .runTotal   (runTotal),
    .suspTotal  (suspTotal),
    .evIdx      (evIdx)
  );

endmodule

// File: rtl/prio_seq_checker.sv
module prio_seq_checker #(
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 5,
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic [CNT_W-1:0]  taskCount,
  input logic              busy,
  input logic              evValid,
  input logic [IDX_W-1:0]  evIdx,
  input logic [MISS_W-1:0] missCount
);

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    evValid |=> !evValid);

  p_event_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> !busy);

  p_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !busy && taskCount >= CNT_W'(2)) |=> busy);

  p_small_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !busy && taskCount < CNT_W'(2)) |=> !busy);

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (CNT_W'(evIdx) < taskCount));

  p_miss_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && busy && !(&missCount)) |=> (missCount == $past(missCount) + MISS_W'(1)));

  p_miss_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(tickIn && busy) |=> $stable(missCount));

endmodule

bind prio_seq_top prio_seq_checker #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .MISS_W(MISS_W)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickIn    (tickIn),
  .taskCount (taskCount),
  .busy      (busy),
  .evValid   (evValid),
  .evIdx     (evIdx),
  .missCount (missCount)
);

// File: tb/prio_seq_top_test.sv
module prio_seq_top_test;

  localparam int MAXT   = 20;
  localparam int PRI_W  = 8;
  localparam int MISS_W = 8;
  localparam int IDX_W  = 5;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickIn = 1'b0;
  logic              bigIsHigh = 1'b1;
  logic [CNT_W-1:0]  taskCount = CNT_W'(5);
  logic              wrEn = 1'b0;
  logic [IDX_W-1:0]  wrIdx = '0;
  logic [PRI_W-1:0]  wrPri = '0;
  logic              busy;
  logic              evValid;
  logic [IDX_W-1:0]  evIdx;
  logic              evAction;
  logic [MISS_W-1:0] missCount;

  int checks = 0;
  int errors = 0;

  int  mPri [MAXT];
  bit  mRun [MAXT];
  bit  mResume = 1'b0;
  int  mMiss = 0;
  int  cnt = 5;
  bit  pol = 1'b1;

  always #2 clk = ~clk;

  prio_seq_top #(.MAX_TASKS(MAXT), .PRI_W(PRI_W), .MISS_W(MISS_W)) uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .bigIsHigh(bigIsHigh),
    .taskCount(taskCount), .wrEn(wrEn), .wrIdx(wrIdx), .wrPri(wrPri),
    .busy(busy), .evValid(evValid), .evIdx(evIdx), .evAction(evAction),
    .missCount(missCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit moreUrgent(input int a, input int b);
    return pol ? (a > b) : (a < b);
  endfunction

  // Reference model of one tick
  task automatic modelStep(output bit v, output int idx, output bit act);
    int runN = 0;
    int suspN = 0;
    int best = -1;
    v = 1'b0; idx = 0; act = mResume;
    if (cnt < 2) return;
    for (int i = 0; i < cnt; i++) begin
      if (mRun[i]) runN++; else suspN++;
      if (!mResume && mRun[i] && (best < 0 || moreUrgent(mPri[i], mPri[best]))) best = i;
      if (mResume && !mRun[i] && (best < 0 || moreUrgent(mPri[best], mPri[i]))) best = i;
    end
    if (!mResume) begin
      if (runN >= 2) begin v = 1'b1; idx = best; mRun[best] = 1'b0; end
      if (runN <= 2) mResume = 1'b1;
    end else begin
      if (suspN >= 1) begin v = 1'b1; idx = best; mRun[best] = 1'b1; end
      if (suspN <= 1) mResume = 1'b0;
    end
  endtask

  task automatic writeEntry(input int i, input int p);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(i); wrPri = PRI_W'(p);
    @(negedge clk);
    wrEn = 1'b0;
    mPri[i] = p; mRun[i] = 1'b1;
  endtask

  task automatic loadRandom();
    int used [MAXT];
    for (int i = 0; i < MAXT; i++) begin
      int p;
      bit dup;
      do begin
        p = int'($urandom % 256);
        dup = 1'b0;
        for (int j = 0; j < i; j++) if (used[j] == p) dup = 1'b1;
      end while (dup);
      used[i] = p;
      writeEntry(i, p);
    end
  endtask

  task automatic setConfig(input int n, input bit polarity);
    @(negedge clk);
    cnt = n; pol = polarity;
    taskCount = CNT_W'(n); bigIsHigh = polarity;
  endtask

  // One tick; optionally inject a second tick during the search
  task automatic doTick(input bit injectMiss, input string tagNoEv);
    bit  v, act;
    int  idx;
    int  cyc = 0;
    string tag;
    modelStep(v, idx, act);
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    if (injectMiss && busy) begin
      tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
      cyc = 1;
      mMiss++;
    end
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
    check(cyc == ((cnt < 2) ? 0 : cnt + 1), "R7 busy length", cyc, (cnt < 2) ? 0 : cnt + 1);
    if (v) begin
      tag = act ? "R4 resume pick" : "R2 suspend pick";
      check(evValid == 1'b1, tag, int'(evValid), 1);
      check(int'(evIdx) == idx, tag, int'(evIdx), idx);
      check(evAction == act, "R3 R5 action order", int'(evAction), int'(act));
      @(negedge clk);
      check(evValid == 1'b0, "R7 one-cycle strobe", int'(evValid), 0);
    end else begin
      check(evValid == 1'b0, tagNoEv, int'(evValid), 0);
    end
    check(int'(missCount) == mMiss, "R8 miss count", int'(missCount), mMiss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MAXT; i++) begin mPri[i] = 0; mRun[i] = 1'b1; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(evValid == 1'b0, "R1 evValid", int'(evValid), 0);
    check(missCount == '0, "R1 missCount", int'(missCount), 0);

    // R2 tie case: equal priorities resolve to lower index
    setConfig(5, 1'b1);
    writeEntry(0, 7); writeEntry(1, 9); writeEntry(2, 9); writeEntry(3, 3); writeEntry(4, 9);
    doTick(1'b0, "R2 tie");
    doTick(1'b0, "R2 tie");

    // R6: count of 1 issues nothing
    setConfig(1, 1'b1);
    doTick(1'b0, "R6 single task");
    doTick(1'b0, "R6 single task");

    // Directed full cycles for 5, 10 and 20 tasks, both polarities
    for (int pass = 0; pass < 6; pass++) begin
      int n = (pass % 3 == 0) ? 5 : (pass % 3 == 1) ? 10 : 20;
      setConfig(n, pass >= 3);
      loadRandom();
      for (int t = 0; t < 2 * n + 2; t++) doTick(t == 3, "R9 no event");
    end

    // R9 and R10: reach refill phase, reload (all running), tick flips phase silently
    setConfig(5, 1'b0);
    loadRandom();
    while (!mResume) doTick(1'b0, "R9 no event");
    loadRandom();
    doTick(1'b0, "R9 R10 reload then empty refill");
    doTick(1'b0, "R9 R10 after flip");

    // Constrained random mix
    for (int r = 0; r < 12; r++) begin
      setConfig(2 + int'($urandom % 19), 1'($urandom));
      if (r % 3 == 0) loadRandom();
      for (int t = 0; t < 10; t++) doTick(($urandom % 4) == 0, "R9 no event");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule